// File: doc/BRIEF.md
# Two-Stage Converter Start-Up and Fault Supervisor

This block sequences and protects a converter made of a power-factor-correction front end and a forward PWM back end. It receives digitized comparator flags and a 1 ms tick enable, and it drives three registered outputs: the front-end enable, the back-end enable and a request to discharge the back end's soft-start capacitor. All outputs are synchronous to one clock.

Nothing runs while the line is below the brownout level. Once the line is good, the front end starts first. The back end starts only after the front-end feedback has stayed above its start level for a set number of ticks. An overload on the back-end feedback that lasts longer than a second tick count shuts the back end off. That shutdown stays latched until the line drops or the block is reset. Front-end feedback faults stop only the front end. A supply over-voltage or a damaged frequency-set pin stops both stages.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: While `line_ok_i` is low, `pfc_en_o` and `pwm_en_o` are 0 and `ss_dis_o` is 1. After reset, all three outputs are in this same state.
- R2: Every flag input passes through a two-flop synchronizer. A flag change made before clock edge k shows up on the outputs after edge k+2, that is, on the third rising edge.
- R3: With the line good and no fault, `pfc_en_o` is 1 and `pwm_en_o` stays 0 until the front end is running.
- R4: `pwm_en_o` rises on the edge after the DLY_TICKS-th `tick_1ms` pulse (default 4) seen while `pfc_fb_ok_i` stays high with the front end enabled. After fewer pulses it is still 0.
- R5: If `pfc_fb_ok_i` drops before the start delay is complete, the tick count restarts from zero.
- R6: If `pwm_ovl_i` stays high with the back end enabled, `pwm_en_o` falls on the same edge that samples the (OVL_TICKS+1)-th tick (default 96). After OVL_TICKS ticks it is still 1.
- R7: If `pwm_ovl_i` goes low, the overload tick count clears.
- R8: An overload shutdown stays latched after `pwm_ovl_i` clears. Only a loss of line (or reset) releases it, and the start sequence then runs again.
- R9: `pfc_ov_i`, `pfc_uv_i` and `pfc_ov2_i` each force `pfc_en_o` to 0 and leave `pwm_en_o` unchanged. When they clear, `pfc_en_o` returns.
- R10: `vdd_ov_i` or `fset_bad_i` forces both enables to 0. When the fault clears, the back end must pass the full start delay again.
- R11: `ss_dis_o` is 1 whenever `pwm_en_o` is 0 or any fault flag is active, and it changes on the same edge as the enable it accompanies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse once per millisecond, synchronous to clk |
| line_ok_i | input | 1 | Line voltage above brownout level |
| pfc_fb_ok_i | input | 1 | Front-end feedback above the back-end start level |
| pfc_ov_i | input | 1 | Front-end feedback over-voltage |
| pfc_uv_i | input | 1 | Front-end feedback under-voltage |
| pfc_ov2_i | input | 1 | Secondary front-end over-voltage input |
| vdd_ov_i | input | 1 | Supply over-voltage |
| fset_bad_i | input | 1 | Frequency-set pin open or shorted |
| pwm_ovl_i | input | 1 | Back-end feedback above the overload level |
| pfc_en_o | output | 1 | Front-end enable |
| pwm_en_o | output | 1 | Back-end enable |
| ss_dis_o | output | 1 | Soft-start discharge request |

## Verification
A flag change reaches the outputs on the third rising edge, after two synchronizer flops and the output register. For this reason the bench drives flags on a falling edge and samples three falling edges later. It also samples once at two falling edges, to show the old value still holds. The tick input is not synchronized. A start or trip that a tick causes therefore appears on that tick's own edge (overload trip) or on the edge after it (back-end start). The bench checks one falling edge after a one-cycle tick pulse. The start-delay and overload thresholds are each checked one tick short of the limit and at the limit.

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor #(
  parameter int DLY_TICKS = 4,
  parameter int OVL_TICKS = 95
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic line_ok_i,
  input  logic pfc_fb_ok_i,
  input  logic pfc_ov_i,
  input  logic pfc_uv_i,
  input  logic pfc_ov2_i,
  input  logic vdd_ov_i,
  input  logic fset_bad_i,
  input  logic pwm_ovl_i,
  output logic pfc_en_o,
  output logic pwm_en_o,
  output logic ss_dis_o
);
  localparam int DW = $clog2(DLY_TICKS + 1);
  localparam int OW = $clog2(OVL_TICKS + 1);
  localparam logic [DW-1:0] DLY_LAST = DW'(DLY_TICKS - 1);
  localparam logic [OW-1:0] OVL_LAST = OW'(OVL_TICKS);

  logic [7:0] raw, meta, sync;
  logic [DW-1:0] dly_cnt;
  logic [OW-1:0] ovl_cnt;
  logic armed, ovl_lat, pfc_q, pwm_q, ss_q;

  assign raw = {pwm_ovl_i, fset_bad_i, vdd_ov_i, pfc_ov2_i,
                pfc_uv_i, pfc_ov_i, pfc_fb_ok_i, line_ok_i};

  wire s_line    = sync[0];
  wire s_fb_ok   = sync[1];
  wire pfc_fault = |sync[4:2];
  wire all_fault = |sync[6:5];
  wire s_ovl     = sync[7];

  wire count_dly = s_line & ~all_fault & pfc_q & s_fb_ok & ~armed;
  wire arm_hit   = count_dly & tick_1ms & (dly_cnt == DLY_LAST);
  wire ovl_run   = s_ovl & pwm_q;
  wire ovl_trip  = ovl_run & tick_1ms & (ovl_cnt == OVL_LAST);

  wire pfc_next = s_line & ~all_fault & ~pfc_fault;
  wire pwm_next = armed & s_line & ~all_fault & ~ovl_lat & ~ovl_trip;
  wire ss_next  = ~pwm_next | pfc_fault | all_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta    <= '0;
      sync    <= '0;
      dly_cnt <= '0;
      ovl_cnt <= '0;
      armed   <= 1'b0;
      ovl_lat <= 1'b0;
      pfc_q   <= 1'b0;
      pwm_q   <= 1'b0;
      ss_q    <= 1'b1;
    end else begin
      meta <= raw;
      sync <= meta;

      if (!count_dly)    dly_cnt <= '0;
      else if (tick_1ms) dly_cnt <= dly_cnt + 1'b1;

      if (!s_line || all_fault) armed <= 1'b0;
      else if (arm_hit)         armed <= 1'b1;

      if (!ovl_run)      ovl_cnt <= '0;
      else if (tick_1ms) ovl_cnt <= ovl_cnt + 1'b1;

      if (!s_line)       ovl_lat <= 1'b0;
      else if (ovl_trip) ovl_lat <= 1'b1;

      pfc_q <= pfc_next;
      pwm_q <= pwm_next;
      ss_q  <= ss_next;
    end
  end

  assign pfc_en_o = pfc_q;
  assign pwm_en_o = pwm_q;
  assign ss_dis_o = ss_q;
endmodule

module pwr_seq_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_1ms,
  input logic line_ok_i,
  input logic pfc_ov_i,
  input logic pfc_uv_i,
  input logic pfc_ov2_i,
  input logic vdd_ov_i,
  input logic fset_bad_i,
  input logic pfc_en_o,
  input logic pwm_en_o,
  input logic ss_dis_o
);
  // R1
  brownout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_ok_i, 3) |-> (!pfc_en_o && !pwm_en_o));
  // R9
  pfc_fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pfc_ov_i, 3) || $past(pfc_uv_i, 3) || $past(pfc_ov2_i, 3)) |-> !pfc_en_o);
  // R10
  global_fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vdd_ov_i, 3) || $past(fset_bad_i, 3)) |-> (!pfc_en_o && !pwm_en_o));
  // R11
  ss_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en_o |-> ss_dis_o);
  // R4
  start_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en_o) |-> $past(tick_1ms, 2));
endmodule

bind pwr_seq_supervisor pwr_seq_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .line_ok_i(line_ok_i),
  .pfc_ov_i(pfc_ov_i), .pfc_uv_i(pfc_uv_i), .pfc_ov2_i(pfc_ov2_i),
  .vdd_ov_i(vdd_ov_i), .fset_bad_i(fset_bad_i),
  .pfc_en_o(pfc_en_o), .pwm_en_o(pwm_en_o), .ss_dis_o(ss_dis_o)
);

// File: tb/sim_pwr_seq_supervisor.sv
module sim_pwr_seq_supervisor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic line = 1'b0, fb_ok = 1'b0, ov = 1'b0, uv = 1'b0, ov2 = 1'b0;
  logic vdd_ov = 1'b0, fset = 1'b0, ovl = 1'b0;
  logic pfc_en, pwm_en, ss_dis;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_seq_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .line_ok_i(line),
    .pfc_fb_ok_i(fb_ok), .pfc_ov_i(ov), .pfc_uv_i(uv), .pfc_ov2_i(ov2),
    .vdd_ov_i(vdd_ov), .fset_bad_i(fset), .pwm_ovl_i(ovl),
    .pfc_en_o(pfc_en), .pwm_en_o(pwm_en), .ss_dis_o(ss_dis)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1); tick = 1'b0; step(1);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic p, input logic w, input logic s);
    chk({req, " pfc_en"}, pfc_en, p);
    chk({req, " pwm_en"}, pwm_en, w);
    chk({req, " ss_dis"}, ss_dis, s);
  endtask

  task automatic bring_up();
    line = 1'b1; fb_ok = 1'b1; step(3);
    tick = 1'b1; step(1); tick = 1'b0; step(1);
    pulse(3);
  endtask

  task automatic power_off();
    line = 1'b0; fb_ok = 1'b0; ovl = 1'b0; step(4);
  endtask

  task automatic t_reset();
    outs("R1 reset", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_startup();
    line = 1'b1; step(2);
    chk("R2 latency pfc_en", pfc_en, 1'b0);
    step(1);
    outs("R3 front end first", 1'b1, 1'b0, 1'b1);
    fb_ok = 1'b1; step(3);
    pulse(2);
    tick = 1'b1; step(1); tick = 1'b0;
    step(1);
    chk("R4 three ticks not enough", pwm_en, 1'b0);
    tick = 1'b1; step(1); tick = 1'b0;
    step(1);
    outs("R4 started after fourth tick", 1'b1, 1'b1, 1'b0);
    power_off();
    outs("R1 brownout", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_delay_restart();
    line = 1'b1; fb_ok = 1'b1; step(3);
    pulse(3);
    fb_ok = 1'b0; step(3);
    fb_ok = 1'b1; step(3);
    pulse(3);
    chk("R5 delay restarted", pwm_en, 1'b0);
    pulse(1);
    chk("R5 full delay after restart", pwm_en, 1'b1);
    power_off();
  endtask

  task automatic t_pfc_faults();
    bring_up();
    chk("R4 bring up", pwm_en, 1'b1);
    ov2 = 1'b1; step(3);
    outs("R9 secondary ov", 1'b0, 1'b1, 1'b1);
    ov2 = 1'b0; step(3);
    outs("R9 recover", 1'b1, 1'b1, 1'b0);
    ov = 1'b1; step(3);
    chk("R9 feedback ov", pfc_en, 1'b0);
    ov = 1'b0; uv = 1'b1; step(3);
    chk("R9 feedback uv", pfc_en, 1'b0);
    chk("R9 uv pwm kept", pwm_en, 1'b1);
    chk("R11 ss on fault", ss_dis, 1'b1);
    uv = 1'b0; step(3);
    power_off();
  endtask

  task automatic t_global();
    bring_up();
    vdd_ov = 1'b1; step(3);
    outs("R10 supply ov", 1'b0, 1'b0, 1'b1);
    vdd_ov = 1'b0; step(3);
    outs("R10 re-sequence", 1'b1, 1'b0, 1'b1);
    pulse(4);
    chk("R10 restart", pwm_en, 1'b1);
    fset = 1'b1; step(2);
    chk("R2 not yet", pwm_en, 1'b1);
    step(1);
    outs("R10 fset pin", 1'b0, 1'b0, 1'b1);
    fset = 1'b0; step(3);
    power_off();
  endtask

  task automatic t_overload();
    bring_up();
    ovl = 1'b1; step(3);
    pulse(95);
    chk("R6 95 ticks kept", pwm_en, 1'b1);
    tick = 1'b1; step(1); tick = 1'b0;
    outs("R6 trip", 1'b1, 1'b0, 1'b1);
    ovl = 1'b0; step(3); pulse(6);
    chk("R8 latched", pwm_en, 1'b0);
    power_off();
    line = 1'b1; fb_ok = 1'b1; step(3);
    chk("R8 released no early start", pwm_en, 1'b0);
    pulse(4);
    chk("R8 restarted", pwm_en, 1'b1);
    power_off();
  endtask

  task automatic t_ovl_clear();
    bring_up();
    ovl = 1'b1; step(3);
    pulse(60);
    ovl = 1'b0; step(3);
    ovl = 1'b1; step(3);
    pulse(95);
    chk("R7 count cleared", pwm_en, 1'b1);
    pulse(1);
    chk("R7 trip after full count", pwm_en, 1'b0);
    power_off();
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_startup();
    t_delay_restart();
    t_pfc_faults();
    t_global();
    t_overload();
    t_ovl_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule